// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block settles every control transfer for an integer pipeline. It receives one resolved request per cycle: the current program counter, the length of the instruction (2 or 4 bytes), two register operands, the immediate, the rd index, a 3-bit operation selector, a 32-bit mode flag and a flag saying whether 16-bit instructions are allowed. From these it works out whether the transfer happens, the address of the next instruction, the return address to write back, and whether an instruction-address-misaligned trap must be raised. It also reports the address that caused the trap.

The comparison and address arithmetic are purely combinational. All results are captured in one output register stage. A result is therefore visible exactly one cycle after its request, qualified by `out_valid`. Fetch, decode, register file access and trap delivery belong to the surrounding pipeline.

Operation selector encoding: 3'b000 equal, 3'b001 not equal, 3'b010 register-indirect jump, 3'b011 reserved, 3'b100 signed less-than, 3'b101 signed greater-or-equal, 3'b110 unsigned less-than, 3'b111 unsigned greater-or-equal.

Top module: `bj_resolve_unit`

## Requirements
- R1: Selector 000 transfers when the two operands are equal, and selector 001 transfers when they differ. In 64-bit mode all bits are compared.
- R2: Selector 100 transfers when operand A is below operand B as two's complement numbers. Selector 101 transfers when it is not.
- R3: Selector 110 transfers when operand A is below operand B as unsigned numbers. Selector 111 transfers when it is not.
- R4: A conditional transfer that happens and does not trap sets `out_taken`=1 and `out_next_pc` = pc + imm.
- R5: A conditional transfer that does not happen sets `out_taken`=0 and `out_next_pc` = pc + length, where the length is 4 when `in_len4`=1 and 2 otherwise. It never raises `out_misalign`, even when the immediate is misaligned.
- R6: Selector 010 targets (operand A + imm) with bit 0 cleared and sets `out_taken`=1 unless it traps.
- R7: When `in_mode32`=1, both operands are compared as their low 32 bits. Every produced address (next pc, return address, fault address) is the low 32 bits of the sum, sign-extended from bit 31.
- R8: A jump that does not trap writes back pc + length. It raises `out_link_we` with `out_link_rd` = rd only when rd is nonzero. When no write happens, `out_link_rd` and `out_link_val` read 0.
- R9: When `in_comp_en`=0 and the jump target has bit 1 set, the unit raises `out_misalign` with `out_fault_addr` = that target. In that case `out_taken`=0, there is no write-back, and `out_next_pc` = pc + length.
- R10: When `in_comp_en`=0 and a conditional transfer happens with imm[1:0] nonzero, the unit raises `out_misalign` with `out_fault_addr` = pc + imm. In that case `out_taken`=0 and `out_next_pc` = pc + length.
- R11: When `in_comp_en`=1 the unit never raises `out_misalign`.
- R12: Results appear one cycle after the request. `out_valid` follows `in_valid`. When `out_valid` is 0, and during reset, all outputs are 0. Selector 011 never transfers, never traps and gives pc + length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation selector |
| in_pc | input | XLEN | Current instruction address |
| in_len4 | input | 1 | 1: 4-byte instruction, 0: 2-byte |
| in_rs1 | input | XLEN | Operand A / jump base |
| in_rs2 | input | XLEN | Operand B |
| in_imm | input | XLEN | Sign-extended immediate |
| in_rd | input | 5 | Destination register index |
| in_mode32 | input | 1 | 32-bit register width mode |
| in_comp_en | input | 1 | 16-bit instructions allowed |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Transfer performed |
| out_next_pc | output | XLEN | Address of the next instruction |
| out_link_we | output | 1 | Write-back of return address |
| out_link_rd | output | 5 | Write-back register index |
| out_link_val | output | XLEN | Return address |
| out_misalign | output | 1 | Instruction-address-misaligned trap |
| out_fault_addr | output | XLEN | Faulting target address |

## Verification
The trap cases are the hardest to reach. A jump traps only when the masked sum has bit 1 set while 16-bit instructions are off. A conditional transfer traps only when its condition holds and the immediate has a low bit set. The same misaligned immediate on a transfer that does not happen must stay silent. Directed requests place each of these cases next to its counterpart with `in_comp_en` raised. Random requests mix the selectors, operand pairs that are often equal or differ only in the sign bit, both modes and both instruction lengths. In 32-bit mode, sums that cross bit 31 exercise the sign-extension of every address output.

// File: rtl/bj_pkg.sv
package bj_pkg;
  typedef enum logic [2:0] {
    OP_EQ   = 3'b000,
    OP_NE   = 3'b001,
    OP_JUMP = 3'b010,
    OP_RSVD = 3'b011,
    OP_LT   = 3'b100,
    OP_GE   = 3'b101,
    OP_LTU  = 3'b110,
    OP_GEU  = 3'b111
  } bj_op_e;

  localparam int unsigned SHORT_LEN = 2;
  localparam int unsigned FULL_LEN  = 4;
  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned RD_BITS   = 5;
endpackage

// File: rtl/bj_cond_eval.sv
module bj_cond_eval
  import bj_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  bj_op_e            op,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic              mode32,
  output logic              is_cond,
  output logic              cond_hit
);
  logic [XLEN-1:0] a_eff, b_eff;
  logic eq, lt_s, lt_u;

  generate
    if (XLEN > WORD_BITS) begin : g_fold
      localparam int unsigned UPPER = XLEN - WORD_BITS;
      assign a_eff = mode32 ? {{UPPER{opa[WORD_BITS-1]}}, opa[WORD_BITS-1:0]} : opa;
      assign b_eff = mode32 ? {{UPPER{opb[WORD_BITS-1]}}, opb[WORD_BITS-1:0]} : opb;
    end else begin : g_pass
      assign a_eff = opa;
      assign b_eff = opb;
    end
  endgenerate

  assign eq   = (a_eff == b_eff);
  assign lt_s = ($signed(a_eff) < $signed(b_eff));
  assign lt_u = (a_eff < b_eff);

  always_comb begin
    is_cond  = 1'b1;
    cond_hit = 1'b0;
    unique case (op)
      OP_EQ:   cond_hit = eq;
      OP_NE:   cond_hit = !eq;
      OP_LT:   cond_hit = lt_s;
      OP_GE:   cond_hit = !lt_s;
      OP_LTU:  cond_hit = lt_u;
      OP_GEU:  cond_hit = !lt_u;
      default: is_cond  = 1'b0;
    endcase
  end
endmodule

// File: rtl/bj_target_gen.sv
module bj_target_gen
  import bj_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] pc,
  input  logic            len4,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] imm,
  input  logic            mode32,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] jmp_tgt
);
  localparam logic [XLEN-1:0] STEP_S = XLEN'(SHORT_LEN);
  localparam logic [XLEN-1:0] STEP_F = XLEN'(FULL_LEN);
  localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

  function automatic logic [XLEN-1:0] fold_word(input logic [XLEN-1:0] v, input logic m32);
    logic [XLEN-1:0] r;
    r = v;
    if (m32) begin
      for (int i = WORD_BITS; i < XLEN; i++) r[i] = v[WORD_BITS-1];
    end
    return r;
  endfunction

  logic [XLEN-1:0] step, seq_raw, br_raw, jmp_raw;

  assign step    = len4 ? STEP_F : STEP_S;
  assign seq_raw = pc + step;
  assign br_raw  = pc + imm;
  assign jmp_raw = (base + imm) & EVEN_MASK;

  assign seq_pc  = fold_word(seq_raw, mode32);
  assign br_tgt  = fold_word(br_raw, mode32);
  assign jmp_tgt = fold_word(jmp_raw, mode32);
endmodule

// File: rtl/bj_align_chk.sv
module bj_align_chk #(
  parameter int unsigned XLEN = 64
) (
  input  logic            comp_en,
  input  logic            is_jump,
  input  logic            cond_take,
  input  logic [1:0]      imm_lo,
  input  logic [XLEN-1:0] br_tgt,
  input  logic [XLEN-1:0] jmp_tgt,
  output logic            fault,
  output logic [XLEN-1:0] fault_addr
);
  logic jump_bad, br_bad;

  assign jump_bad = !comp_en && is_jump && jmp_tgt[1];
  assign br_bad   = !comp_en && cond_take && (imm_lo != 2'b00);

  assign fault = jump_bad || br_bad;

  always_comb begin
    fault_addr = '0;
    if (jump_bad)    fault_addr = jmp_tgt;
    else if (br_bad) fault_addr = br_tgt;
  end
endmodule

// File: rtl/bj_resolve_unit.sv
module bj_resolve_unit
  import bj_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [XLEN-1:0]   in_pc,
  input  logic              in_len4,
  input  logic [XLEN-1:0]   in_rs1,
  input  logic [XLEN-1:0]   in_rs2,
  input  logic [XLEN-1:0]   in_imm,
  input  logic [4:0]        in_rd,
  input  logic              in_mode32,
  input  logic              in_comp_en,
  output logic              out_valid,
  output logic              out_taken,
  output logic [XLEN-1:0]   out_next_pc,
  output logic              out_link_we,
  output logic [4:0]        out_link_rd,
  output logic [XLEN-1:0]   out_link_val,
  output logic              out_misalign,
  output logic [XLEN-1:0]   out_fault_addr
);
  bj_op_e          op;
  logic            is_cond, cond_hit, is_jump, cond_take, want_xfer;
  logic            align_fault;
  logic [XLEN-1:0] seq_pc, br_tgt, jmp_tgt, fault_addr;
  logic            taken_d, link_we_d;
  logic [XLEN-1:0] next_d, link_val_d;

  assign op      = bj_op_e'(in_op);
  assign is_jump = (op == OP_JUMP);

  bj_cond_eval #(.XLEN(XLEN)) u_cond (
    .op       (op),
    .opa      (in_rs1),
    .opb      (in_rs2),
    .mode32   (in_mode32),
    .is_cond  (is_cond),
    .cond_hit (cond_hit)
  );

  bj_target_gen #(.XLEN(XLEN)) u_tgt (
    .pc      (in_pc),
    .len4    (in_len4),
    .base    (in_rs1),
    .imm     (in_imm),
    .mode32  (in_mode32),
    .seq_pc  (seq_pc),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt)
  );

  assign cond_take = is_cond && cond_hit;
  assign want_xfer = cond_take || is_jump;

  bj_align_chk #(.XLEN(XLEN)) u_align (
    .comp_en    (in_comp_en),
    .is_jump    (is_jump),
    .cond_take  (cond_take),
    .imm_lo     (in_imm[1:0]),
    .br_tgt     (br_tgt),
    .jmp_tgt    (jmp_tgt),
    .fault      (align_fault),
    .fault_addr (fault_addr)
  );

  assign taken_d    = want_xfer && !align_fault;
  assign link_we_d  = is_jump && !align_fault && (in_rd != '0);
  assign link_val_d = link_we_d ? seq_pc : '0;

  always_comb begin
    next_d = seq_pc;
    if (taken_d) next_d = is_jump ? jmp_tgt : br_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_taken      <= 1'b0;
      out_next_pc    <= '0;
      out_link_we    <= 1'b0;
      out_link_rd    <= '0;
      out_link_val   <= '0;
      out_misalign   <= 1'b0;
      out_fault_addr <= '0;
    end else if (in_valid) begin
      out_valid      <= 1'b1;
      out_taken      <= taken_d;
      out_next_pc    <= next_d;
      out_link_we    <= link_we_d;
      out_link_rd    <= link_we_d ? in_rd : '0;
      out_link_val   <= link_val_d;
      out_misalign   <= align_fault;
      out_fault_addr <= fault_addr;
    end else begin
      out_valid      <= 1'b0;
      out_taken      <= 1'b0;
      out_next_pc    <= '0;
      out_link_we    <= 1'b0;
      out_link_rd    <= '0;
      out_link_val   <= '0;
      out_misalign   <= 1'b0;
      out_fault_addr <= '0;
    end
  end
endmodule

// File: rtl/bj_resolve_checker.sv
module bj_resolve_checker #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      in_op,
  input logic            in_mode32,
  input logic            in_comp_en,
  input logic            is_cond,
  input logic            cond_hit,
  input logic            out_valid,
  input logic            out_taken,
  input logic [XLEN-1:0] out_next_pc,
  input logic            out_link_we,
  input logic [4:0]      out_link_rd,
  input logic            out_misalign
);
  assert_misalign_qualified_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_misalign |-> out_valid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_taken && !out_misalign && !out_link_we));

  assert_fault_blocks_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_misalign |-> (!out_taken && !out_link_we));

  assert_rd0_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_link_we |-> (out_link_rd != 5'd0));

  assert_jump_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'b010) |=> (out_misalign || !out_next_pc[0]));

  assert_untaken_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cond && !cond_hit) |=> !out_misalign);

  assert_comp_no_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_comp_en) |=> !out_misalign);

  generate
    if (XLEN > 32) begin : g_wide
      localparam int unsigned UPPER = XLEN - 31;
      assert_m32_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode32) |=>
          ($countones(out_next_pc[XLEN-1:31]) == 0 || $countones(out_next_pc[XLEN-1:31]) == UPPER));
    end
  endgenerate
endmodule

bind bj_resolve_unit bj_resolve_checker #(.XLEN(XLEN)) u_bj_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_op        (in_op),
  .in_mode32    (in_mode32),
  .in_comp_en   (in_comp_en),
  .is_cond      (is_cond),
  .cond_hit     (cond_hit),
  .out_valid    (out_valid),
  .out_taken    (out_taken),
  .out_next_pc  (out_next_pc),
  .out_link_we  (out_link_we),
  .out_link_rd  (out_link_rd),
  .out_misalign (out_misalign)
);

// File: tb/test_bj_resolve_unit.sv
module test_bj_resolve_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [63:0] in_pc = '0, in_rs1 = '0, in_rs2 = '0, in_imm = '0;
  logic        in_len4 = 1'b0, in_mode32 = 1'b0, in_comp_en = 1'b0;
  logic [4:0]  in_rd = '0;
  logic        out_valid, out_taken, out_link_we, out_misalign;
  logic [63:0] out_next_pc, out_link_val, out_fault_addr;
  logic [4:0]  out_link_rd;

  always #5 clk = ~clk;

  bj_resolve_unit #(.XLEN(64)) i_bj_resolve_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_pc(in_pc),
    .in_len4(in_len4), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_imm(in_imm), .in_rd(in_rd),
    .in_mode32(in_mode32), .in_comp_en(in_comp_en), .out_valid(out_valid),
    .out_taken(out_taken), .out_next_pc(out_next_pc), .out_link_we(out_link_we),
    .out_link_rd(out_link_rd), .out_link_val(out_link_val), .out_misalign(out_misalign),
    .out_fault_addr(out_fault_addr)
  );

  typedef struct packed {
    logic        v, tk;
    logic [63:0] np;
    logic        we;
    logic [4:0]  rd;
    logic [63:0] lv;
    logic        mis;
    logic [63:0] fa;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0, n_fail = 0;
  bit    done = 0;

  function automatic logic [63:0] wrap(input logic [63:0] x, input logic m32);
    if (m32) return longint'($signed(x[31:0]));
    return x;
  endfunction

  function automatic res_t model(input logic v, input logic [2:0] op, input logic [63:0] pc,
                                 input logic l4, input logic [63:0] a, input logic [63:0] b,
                                 input logic [63:0] imm, input logic [4:0] rd,
                                 input logic m32, input logic ce);
    res_t r = '0;
    logic [63:0] seq, brt, jt;
    bit eq, lt, ltu, hit, cond;
    if (!v) return r;
    r.v = 1;
    seq = wrap(pc + (l4 ? 64'd4 : 64'd2), m32);
    brt = wrap(pc + imm, m32);
    jt  = wrap((a + imm) & ~64'd1, m32);
    if (m32) begin
      eq = a[31:0] == b[31:0]; lt = $signed(a[31:0]) < $signed(b[31:0]); ltu = a[31:0] < b[31:0];
    end else begin
      eq = a == b; lt = $signed(a) < $signed(b); ltu = a < b;
    end
    cond = 1; hit = 0;
    case (op)
      3'd0: hit = eq;   3'd1: hit = !eq;
      3'd4: hit = lt;   3'd5: hit = !lt;
      3'd6: hit = ltu;  3'd7: hit = !ltu;
      default: cond = 0;
    endcase
    r.np = seq;
    if (op == 3'd2) begin
      if (!ce && jt[1]) begin r.mis = 1; r.fa = jt; end
      else begin
        r.tk = 1; r.np = jt;
        if (rd != 0) begin r.we = 1; r.rd = rd; r.lv = seq; end
      end
    end else if (cond && hit) begin
      if (!ce && imm[1:0] != 0) begin r.mis = 1; r.fa = brt; end
      else begin r.tk = 1; r.np = brt; end
    end
    return r;
  endfunction

  function automatic res_t observed();
    res_t g;
    g.v = out_valid; g.tk = out_taken; g.np = out_next_pc; g.we = out_link_we;
    g.rd = out_link_rd; g.lv = out_link_val; g.mis = out_misalign; g.fa = out_fault_addr;
    return g;
  endfunction

  task automatic compare_head();
    res_t e, g;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    g = observed();
    n_checks++;
    if (g !== e) begin
      n_fail++;
      $display("FAIL %s: got v=%0b tk=%0b np=%h we=%0b rd=%0d lv=%h mis=%0b fa=%h exp v=%0b tk=%0b np=%h we=%0b rd=%0d lv=%h mis=%0b fa=%h",
               t, g.v, g.tk, g.np, g.we, g.rd, g.lv, g.mis, g.fa,
               e.v, e.tk, e.np, e.we, e.rd, e.lv, e.mis, e.fa);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [63:0] pc, input logic l4,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] imm,
                      input logic [4:0] rd, input logic m32, input logic ce, input string tag);
    @(negedge clk);
    compare_head();
    in_valid = v; in_op = op; in_pc = pc; in_len4 = l4; in_rs1 = a; in_rs2 = b;
    in_imm = imm; in_rd = rd; in_mode32 = m32; in_comp_en = ce;
    exp_q.push_back(model(v, op, pc, l4, a, b, imm, rd, m32, ce));
    tag_q.push_back(tag);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    exp_q.push_back('0); tag_q.push_back("R12 reset");
    compare_head();
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 idle");
    step(1, 3'd0, 64'h1000, 1, 64'h55, 64'h55, 64'h20, 1, 0, 0, "R1 eq taken R4");
    step(1, 3'd1, 64'h1000, 1, 64'h55, 64'h55, 64'h20, 1, 0, 0, "R1 ne untaken");
    step(1, 3'd0, 64'h1000, 1, 64'h8000_0000_0000_0001, 64'h1, 64'h20, 1, 0, 0, "R1 eq msb differs");
    step(1, 3'd4, 64'h1000, 1, -64'sd1, 64'd1, 64'h40, 1, 0, 0, "R2 lt signed");
    step(1, 3'd5, 64'h1000, 1, -64'sd5, -64'sd5, 64'h40, 1, 0, 0, "R2 ge equal");
    step(1, 3'd6, 64'h1000, 1, 64'd1, -64'sd1, 64'h40, 1, 0, 0, "R3 ltu");
    step(1, 3'd7, 64'h1000, 1, 64'd1, -64'sd1, 64'h40, 1, 0, 0, "R3 geu untaken");
    step(1, 3'd0, 64'h2000, 1, 64'd0, 64'd0, -64'sd16, 1, 0, 0, "R4 backward");
    step(1, 3'd1, 64'h2000, 0, 64'd7, 64'd7, 64'h6, 1, 0, 0, "R5 untaken misaligned imm");
    step(1, 3'd2, 64'h3000, 1, 64'h3001, 64'd0, 64'h10, 7, 0, 1, "R6 jump clears bit0 R8");
    step(1, 3'd2, 64'h0, 1, 64'h7FFF_FFF0, 64'd0, 64'h20, 3, 1, 1, "R7 jump sext");
    step(1, 3'd0, 64'h7FFF_FFFC, 1, 64'h1_0000_0009, 64'h2_0000_0009, 64'h8, 1, 1, 0, "R7 eq low word");
    step(1, 3'd2, 64'h100, 0, 64'h800, 64'd0, 64'h0, 5, 0, 0, "R8 link short");
    step(1, 3'd2, 64'h100, 1, 64'h800, 64'd0, 64'h0, 0, 0, 0, "R8 rd zero");
    step(1, 3'd2, 64'h100, 1, 64'h4000, 64'd0, 64'h2, 9, 0, 0, "R9 jump fault");
    step(1, 3'd0, 64'h500, 1, 64'd3, 64'd3, 64'h6, 1, 0, 0, "R10 branch fault");
    step(1, 3'd0, 64'h500, 1, 64'd3, 64'd3, 64'h6, 1, 0, 1, "R11 branch comp");
    step(1, 3'd2, 64'h100, 1, 64'h4000, 64'd0, 64'h2, 9, 0, 1, "R11 jump comp");
    step(1, 3'd3, 64'h900, 0, 64'd1, 64'd1, 64'h2, 4, 0, 0, "R12 reserved op");
    step(0, 3'd2, 64'h900, 0, 64'd1, 64'd1, 64'h2, 4, 0, 0, "R12 invalid");
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b, imm, pc;
      a = {$urandom, $urandom};
      case ($urandom_range(3))
        0: b = a;
        1: b = a ^ 64'h8000_0000_0000_0000;
        2: b = a ^ 64'h8000_0000;
        default: b = {$urandom, $urandom};
      endcase
      imm = 64'($signed(13'($urandom_range(8191))));
      pc  = {$urandom, $urandom} & ~64'd1;
      if ($urandom_range(1)) pc = {32'd0, 1'b0, pc[30:0]};
      step($urandom_range(9) != 0, 3'($urandom_range(7)), pc, 1'($urandom), a, b, imm,
           5'($urandom), 1'($urandom), 1'($urandom), "R1 R2 R3 R7 R9 R10 random");
    end
    @(negedge clk);
    compare_head();
    finish_run();
  end
endmodule